// File: doc/BRIEF.md
# Monotonic Sector Protection Register

This block holds the 8-bit setting that tells a program-memory controller which sectors are shielded from program and erase commands. There are two independent regions, a low one and a high one. Each has a disable flag and a 2-bit size code. A global mode bit sits above the two regions. A reserved bit rides along with the others.

During the reset sequence, a loader feeds the block the configuration byte read from nonvolatile storage, together with a flag that says the read hit an uncorrectable (double-bit) fault. A faulty load forces the most protective image. Once the loader signals that it is finished, the block accepts software writes. It accepts a write only when the write keeps or enlarges the protected area. Any other write is dropped whole and reported by a one-cycle pulse.

The block presents the stored byte and the decoded controls for each region: an active flag, the size code, and a span in sectors. The address comparison against these spans is done elsewhere.

Top module: `sector_guard_reg`

## Requirements
- R1: While `rst` is high and afterwards until the first load, `prot_q` is 8'h7F, `ready` is 0 and `wr_reject` is 0.
- R2: While `ready` is 0, a `cfg_load` pulse without `cfg_dbl_fault` copies `cfg_byte` into `prot_q` on the next clock edge. A later pulse before `ready` overwrites the earlier one.
- R3: While `ready` is 0, a `cfg_load` pulse with `cfg_dbl_fault` high stores {0, cfg_byte[6], 6'b111111}. Bit 7 is cleared and bits 5:0 are all set.
- R4: A `load_done` pulse sets `ready` on the next edge. Until then, `wr_en` has no effect and gives no `wr_reject`. Once `ready` is 1, `cfg_load` has no effect.
- R5: Bit 7 (mode) may be written from 1 to 0. A write that changes it from 0 to 1 is rejected.
- R6: A region is enabled when its disable bit is 0. The low region uses disable bit 2 and size bits 1:0; the high region uses disable bit 5 and size bits 4:3. For an enabled region, a write that sets its disable bit or lowers its size code is rejected. A write with an equal or larger size code is accepted.
- R7: For a disabled region, a write may clear its disable bit (enable it) with any size code, or change its size code while leaving it disabled.
- R8: Bit 6 is never changed by a software write. An otherwise acceptable write that differs only in bit 6 is accepted and leaves bit 6 as it was.
- R9: A rejected write leaves every bit of `prot_q` unchanged, and `wr_reject` is high for exactly the following cycle. An accepted write produces no pulse.
- R10: `lo_on` is the inverse of bit 2 and `lo_sz` equals bits 1:0. `lo_span` is LO_BASE << bits 1:0 when `lo_on` is 1, and 0 otherwise. `hi_on`, `hi_sz` and `hi_span` follow the same rule with bit 5, bits 4:3 and HI_BASE. `open_mode` equals bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe carrying the configuration byte from the reset loader |
| cfg_byte | input | 8 | Configuration byte read from nonvolatile storage |
| cfg_dbl_fault | input | 1 | Uncorrectable fault reported for the configuration read |
| load_done | input | 1 | Reset loader has finished |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value |
| prot_q | output | 8 | Stored protection byte |
| ready | output | 1 | Software writes are accepted |
| wr_reject | output | 1 | One-cycle pulse after a rejected write |
| open_mode | output | 1 | Mode bit (bit 7) |
| lo_on | output | 1 | Low region active |
| lo_sz | output | 2 | Low region size code |
| lo_span | output | SPAN_W | Low region span in sectors |
| hi_on | output | 1 | High region active |
| hi_sz | output | 2 | High region size code |
| hi_span | output | SPAN_W | High region span in sectors |

## Verification
On every cycle the assertions check the following. The reserved bit and the mode bit never move the wrong way once `ready` is high. An enabled region never shrinks or turns off. The byte holds still before `ready` unless a load arrives. A reject pulse always follows a real write, and the byte did not change across it. Only the bench's directed scenarios can show the exact images stored after clean and faulty loads, how each individual write is classified, and the decoded spans. Those need expected values worked out from the requirements.

// File: rtl/sgr_pkg.sv
package sgr_pkg;
  localparam int MODE_B   = 7;
  localparam int RSVD_B   = 6;
  localparam int HI_DIS_B = 5;
  localparam int HI_SZ_LO = 3;
  localparam int LO_DIS_B = 2;
  localparam int LO_SZ_LO = 0;
  localparam logic [7:0] RESET_IMAGE = 8'h7F;

  typedef struct packed {
    logic       dis;
    logic [1:0] sz;
  } region_t;

  function automatic region_t get_region(input logic [7:0] b, input logic hi);
    region_t r;
    if (hi) begin
      r.dis = b[HI_DIS_B];
      r.sz  = b[HI_SZ_LO +: 2];
    end else begin
      r.dis = b[LO_DIS_B];
      r.sz  = b[LO_SZ_LO +: 2];
    end
    return r;
  endfunction

  // an enabled region may neither switch off nor shrink
  function automatic logic region_grows(input region_t old_r, input region_t new_r);
    if (old_r.dis) return 1'b1;
    return (!new_r.dis) && (new_r.sz >= old_r.sz);
  endfunction

  function automatic logic image_grows(input logic [7:0] old_b, input logic [7:0] new_b);
    logic mode_ok;
    mode_ok = !(!old_b[MODE_B] && new_b[MODE_B]);
    return mode_ok
        && region_grows(get_region(old_b, 1'b0), get_region(new_b, 1'b0))
        && region_grows(get_region(old_b, 1'b1), get_region(new_b, 1'b1));
  endfunction

  function automatic logic [7:0] fault_image(input logic [7:0] cfg);
    logic [7:0] f;
    f = 8'h3F;
    f[RSVD_B] = cfg[RSVD_B];
    return f;
  endfunction
endpackage

// File: rtl/sgr_load_ctrl.sv
module sgr_load_ctrl
  import sgr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_load,
  input  logic [7:0] cfg_byte,
  input  logic       cfg_dbl_fault,
  input  logic       load_done,
  output logic       ready,
  output logic       load_fire,
  output logic [7:0] load_image
);
  assign load_fire  = cfg_load && !ready;
  assign load_image = cfg_dbl_fault ? fault_image(cfg_byte) : cfg_byte;

  always_ff @(posedge clk) begin
    if (rst)            ready <= 1'b0;
    else if (load_done) ready <= 1'b1;
  end
endmodule

// File: rtl/sgr_write_filter.sv
module sgr_write_filter
  import sgr_pkg::*;
(
  input  logic       ready,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [7:0] cur,
  output logic       wr_accept,
  output logic       wr_deny,
  output logic [7:0] wr_image
);
  logic [7:0] cand;
  logic       grows;

  always_comb begin
    cand         = wr_data;
    cand[RSVD_B] = cur[RSVD_B];
  end

  assign grows     = image_grows(cur, cand);
  assign wr_accept = ready && wr_en && grows;
  assign wr_deny   = ready && wr_en && !grows;
  assign wr_image  = cand;
endmodule

// File: rtl/sgr_region_decode.sv
module sgr_region_decode #(
  parameter int BASE   = 1,
  parameter int SPAN_W = 8
) (
  input  logic              dis,
  input  logic [1:0]        sz,
  output logic              on,
  output logic [1:0]        sz_o,
  output logic [SPAN_W-1:0] span
);
  localparam logic [SPAN_W-1:0] BASE_V = SPAN_W'(BASE);
  assign on   = !dis;
  assign sz_o = sz;
  assign span = on ? (BASE_V << sz) : '0;
endmodule

// File: rtl/sector_guard_reg.sv
module sector_guard_reg
  import sgr_pkg::*;
#(
  parameter int LO_BASE = 1,
  parameter int HI_BASE = 2,
  parameter int SPAN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [7:0]        cfg_byte,
  input  logic              cfg_dbl_fault,
  input  logic              load_done,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        prot_q,
  output logic              ready,
  output logic              wr_reject,
  output logic              open_mode,
  output logic              lo_on,
  output logic [1:0]        lo_sz,
  output logic [SPAN_W-1:0] lo_span,
  output logic              hi_on,
  output logic [1:0]        hi_sz,
  output logic [SPAN_W-1:0] hi_span
);
  localparam int NREG = 2;

  logic       load_fire, wr_accept, wr_deny;
  logic [7:0] load_image, wr_image;

  sgr_load_ctrl u_load (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_byte(cfg_byte),
    .cfg_dbl_fault(cfg_dbl_fault), .load_done(load_done),
    .ready(ready), .load_fire(load_fire), .load_image(load_image)
  );

  sgr_write_filter u_filt (
    .ready(ready), .wr_en(wr_en), .wr_data(wr_data), .cur(prot_q),
    .wr_accept(wr_accept), .wr_deny(wr_deny), .wr_image(wr_image)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q    <= RESET_IMAGE;
      wr_reject <= 1'b0;
    end else begin
      wr_reject <= wr_deny;
      if (load_fire)      prot_q <= load_image;
      else if (wr_accept) prot_q <= wr_image;
    end
  end

  assign open_mode = prot_q[MODE_B];

  logic              r_on   [NREG];
  logic [1:0]        r_sz   [NREG];
  logic [SPAN_W-1:0] r_span [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int BASE_G = (g == 0) ? LO_BASE : HI_BASE;
    region_t rg;
    assign rg = get_region(prot_q, (g == 1));
    sgr_region_decode #(.BASE(BASE_G), .SPAN_W(SPAN_W)) u_dec (
      .dis(rg.dis), .sz(rg.sz), .on(r_on[g]), .sz_o(r_sz[g]), .span(r_span[g])
    );
  end

  assign lo_on   = r_on[0];
  assign lo_sz   = r_sz[0];
  assign lo_span = r_span[0];
  assign hi_on   = r_on[1];
  assign hi_sz   = r_sz[1];
  assign hi_span = r_span[1];
endmodule

// File: rtl/sgr_checker.sv
module sgr_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_load,
  input logic       wr_en,
  input logic       ready,
  input logic       wr_reject,
  input logic [7:0] prot_q
);
  AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (rst)
    ready |=> prot_q[6] == $past(prot_q[6])); // R8
  AST_MODE_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (ready && !prot_q[7]) |=> !prot_q[7]); // R5
  AST_LO_NO_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (ready && !prot_q[2]) |=> (!prot_q[2] && prot_q[1:0] >= $past(prot_q[1:0]))); // R6
  AST_HI_NO_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (ready && !prot_q[5]) |=> (!prot_q[5] && prot_q[4:3] >= $past(prot_q[4:3]))); // R6
  AST_PRE_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ready && !cfg_load) |=> $stable(prot_q)); // R4
  AST_REJECT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_reject |-> $past(wr_en && ready)); // R9
  AST_REJECT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    wr_reject |-> prot_q == $past(prot_q)); // R9
endmodule

bind sector_guard_reg sgr_checker u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .wr_en(wr_en),
  .ready(ready), .wr_reject(wr_reject), .prot_q(prot_q)
);

// File: tb/sector_guard_reg_tb.sv
module sector_guard_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LO_B = 1;
  localparam int HI_B = 2;
  localparam int SW   = 8;

  logic clk = 1'b0;
  logic rst, cfg_load, cfg_dbl_fault, load_done, wr_en;
  logic [7:0] cfg_byte, wr_data, prot_q;
  logic ready, wr_reject, open_mode, lo_on, hi_on;
  logic [1:0] lo_sz, hi_sz;
  logic [SW-1:0] lo_span, hi_span;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_guard_reg #(.LO_BASE(LO_B), .HI_BASE(HI_B), .SPAN_W(SW)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_byte(cfg_byte),
    .cfg_dbl_fault(cfg_dbl_fault), .load_done(load_done), .wr_en(wr_en),
    .wr_data(wr_data), .prot_q(prot_q), .ready(ready), .wr_reject(wr_reject),
    .open_mode(open_mode), .lo_on(lo_on), .lo_sz(lo_sz), .lo_span(lo_span),
    .hi_on(hi_on), .hi_sz(hi_sz), .hi_span(hi_span)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // independent restatement of the decode rule
  task automatic chk_decode(input string req, input logic [7:0] b);
    logic lon, hon;
    int ls, hs;
    lon = (b[2] == 1'b0);
    hon = (b[5] == 1'b0);
    ls  = lon ? LO_B * (2 ** b[1:0]) : 0;
    hs  = hon ? HI_B * (2 ** b[4:3]) : 0;
    chk(req, "prot_q", prot_q, b);
    chk(req, "open_mode", open_mode, b[7]);
    chk(req, "lo_on", lo_on, lon);
    chk(req, "lo_sz", lo_sz, b[1:0]);
    chk(req, "lo_span", lo_span, ls);
    chk(req, "hi_on", hi_on, hon);
    chk(req, "hi_sz", hi_sz, b[4:3]);
    chk(req, "hi_span", hi_span, hs);
  endtask

  task automatic do_load(input logic [7:0] b, input logic f);
    @(negedge clk);
    cfg_load = 1'b1; cfg_byte = b; cfg_dbl_fault = f;
    @(negedge clk);
    cfg_load = 1'b0; cfg_dbl_fault = 1'b0;
  endtask

  // write, then check the byte and the pulse one cycle later
  task automatic do_write(input string req, input logic [7:0] d,
                          input logic [7:0] exp_b, input logic exp_rej);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(req, "prot_q after write", prot_q, exp_b);
    chk(req, "wr_reject", wr_reject, exp_rej);
    @(negedge clk);
    chk("R9", "wr_reject drops", wr_reject, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; cfg_load = 0; cfg_byte = 0; cfg_dbl_fault = 0;
    load_done = 0; wr_en = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_decode("R1", 8'h7F);
    chk("R1", "ready", ready, 0);
    chk("R1", "wr_reject", wr_reject, 0);
  endtask

  task automatic t_preready_write;
    do_write("R4", 8'h00, 8'h7F, 1'b0);
  endtask

  task automatic t_loads;
    do_load(8'h00, 1'b1);
    chk_decode("R3", 8'h3F);
    do_load(8'hC0, 1'b1);
    chk_decode("R3", 8'h7F);
    do_load(8'hA1, 1'b0);
    chk_decode("R2", 8'hA1);
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
    chk("R4", "ready", ready, 1);
    do_load(8'h00, 1'b0);
    chk_decode("R4", 8'hA1);
  endtask

  task automatic t_enabled_region;
    do_write("R6", 8'hA0, 8'hA1, 1'b1); // low size down
    do_write("R6", 8'hA5, 8'hA1, 1'b1); // low disable set
    do_write("R6", 8'hA3, 8'hA3, 1'b0); // low size up
    chk_decode("R10", 8'hA3);
  endtask

  task automatic t_disabled_region;
    do_write("R7", 8'hB3, 8'hB3, 1'b0); // high size change while off
    do_write("R7", 8'h93, 8'h93, 1'b0); // enable high
    chk_decode("R10", 8'h93);
  endtask

  task automatic t_reserved;
    do_write("R8", 8'hD3, 8'h93, 1'b0);
  endtask

  task automatic t_mode;
    do_write("R5", 8'h13, 8'h13, 1'b0);
    do_write("R5", 8'h93, 8'h13, 1'b1);
  endtask

  task automatic t_mixed;
    do_write("R9", 8'h1A, 8'h13, 1'b1); // high grows, low shrinks
    do_write("R6", 8'h13, 8'h13, 1'b0); // equal image
    do_write("R6", 8'h1B, 8'h1B, 1'b0); // high up to max
    chk_decode("R10", 8'h1B);
  endtask

  initial begin
    t_reset();
    t_preready_write();
    t_loads();
    t_enabled_region();
    t_disabled_region();
    t_reserved();
    t_mode();
    t_mixed();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule